// File: doc/BRIEF.md
# I2C SCL Clock Generator with Low-Hang Watchdog

This block produces the clock waveform that an I2C master places on SCL. The low and high phases each have their own length, counted in peripheral clock cycles from an 8-bit count. The output is an open-drain pull-down request, `scl_drive`. When it is 1 the pad pulls SCL low. When it is 0 the line floats high.

The block also watches the sampled SCL level for a bus hang. It does this whether the controller is the master or a slave. The watchdog counts uninterrupted SCL-low time in units of 32 clock cycles. When the programmed number of units has passed, it does three things:

- sets a sticky timeout flag;
- pulses an interrupt for one cycle;
- asks the surrounding transfer logic to return to idle and release both SCL and SDA.

A write to the control register or to the transmit-data register clears the flag. All pins are plain control and status levels. The block has no streaming data interface.

Top module: `scl_timing_top`

## Requirements
- R1: After reset, `scl_drive`, `bus_release`, `to_flag` and `to_irq` are all 0.
- R2: While `en` is 1 and no timeout is pending, SCL runs in phases. The first phase is low and starts on the clock edge after `en` is first sampled 1. A low phase holds `scl_drive`=1 for `lo_cnt`+1 cycles. A high phase holds `scl_drive`=0 for `hi_cnt`+1 cycles. The two phases alternate.
- R3: `lo_cnt` or `hi_cnt` may change while a phase is running. The phase in progress keeps the length latched when it began. The new value is used from the next phase of that kind.
- R4: While `en` is 0, `scl_drive` is 0 in the same cycle. When `en` returns to 1, the waveform restarts with a fresh low phase.
- R5: When `to_limit` is 0, `to_flag` never sets.
- R6: When `to_limit`=N is nonzero, `to_flag` becomes 1 after the clock edge on which `scl_in` has been sampled 0 on N×32 consecutive edges. Any edge that samples `scl_in`=1 restarts the count.
- R7: `to_irq` is 1 for exactly the one cycle after the edge that sets `to_flag`. `to_flag` then stays 1 until it is cleared.
- R8: A 1 on `ctrl_wr` or `txd_wr` clears `to_flag` on that edge. It also restarts the low-time count, and that edge does not count as a low sample.
- R9: While `to_flag` is 1, `bus_release` is 1 and `scl_drive` is 0.
- R10: The watchdog runs regardless of `en`, so a hang caused by another master or a slave is also caught.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock generator enable |
| scl_in | input | 1 | Sampled SCL line level |
| hi_cnt | input | 8 | High phase length minus one |
| lo_cnt | input | 8 | Low phase length minus one |
| to_limit | input | 16 | Timeout in 32-cycle units; 0 disables |
| ctrl_wr | input | 1 | Control register write strobe |
| txd_wr | input | 1 | Transmit-data register write strobe |
| scl_drive | output | 1 | Pull SCL low when 1 |
| bus_release | output | 1 | Request to idle and release SCL and SDA |
| to_flag | output | 1 | Sticky timeout status |
| to_irq | output | 1 | One-cycle timeout interrupt pulse |

## Verification
The phase state, the timeout flag and the interrupt are registers, so each responds on the first rising edge after it samples the input. The exception is the gating of `scl_drive` by `en` and by the flag, which acts in the same cycle.

The bench drives inputs on the falling edge and steps its reference model on the rising edge. It compares every output at the following falling edge, so each expected value sits one edge behind the stimulus that caused it. SCL is modelled as a wired line that is low whenever the block or an external holder pulls it. Timeouts therefore come from both the block's own long low phases and outside holds.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int CNT_W   = 8;
  localparam int TO_W    = 16;
  localparam int UNIT_LG = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;
endpackage

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] hi_cnt,
  input  logic [W-1:0] lo_cnt,
  output logic         low_phase
);
  phase_t       state;
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      remain <= '0;
    end else if (!run) begin
      state  <= PH_IDLE;
      remain <= '0;
    end else begin
      case (state)
        PH_IDLE: begin
          state  <= PH_LOW;
          remain <= lo_cnt;
        end
        PH_LOW: begin
          if (remain == '0) begin
            state  <= PH_HIGH;
            remain <= hi_cnt;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        PH_HIGH: begin
          if (remain == '0) begin
            state  <= PH_LOW;
            remain <= lo_cnt;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign low_phase = (state == PH_LOW);

  // R4: a stopped generator is idle on the next edge
  a_r4_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (state == PH_IDLE));
  // R2: the phase that follows idle is always a low phase
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == PH_IDLE) |=> (state == PH_LOW || !$past(run)));
endmodule

// File: rtl/scl_hang_watch.sv
module scl_hang_watch
  import scl_pkg::*;
#(
  parameter int TW = TO_W,
  parameter int PW = UNIT_LG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic [TW-1:0] to_limit,
  input  logic          clr,
  output logic          to_flag,
  output logic          to_irq
);
  logic [PW-1:0] pre;
  logic [TW-1:0] units;
  logic          hit;

  assign hit = !scl_in && (to_limit != '0) && (pre == '1) &&
               (units == to_limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      units   <= '0;
      to_flag <= 1'b0;
      to_irq  <= 1'b0;
    end else begin
      to_irq <= 1'b0;
      if (clr) begin
        to_flag <= 1'b0;
        pre     <= '0;
        units   <= '0;
      end else if (to_flag || scl_in || to_limit == '0) begin
        pre   <= '0;
        units <= '0;
      end else if (hit) begin
        to_flag <= 1'b1;
        to_irq  <= 1'b1;
        pre     <= '0;
        units   <= '0;
      end else begin
        pre <= pre + 1'b1;
        if (pre == '1) units <= units + 1'b1;
      end
    end
  end

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    to_irq |=> !to_irq);
  a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    to_irq |-> to_flag);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !to_flag);
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (to_limit == '0 && !to_flag) |=> !to_flag);
  a_r6_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && !to_flag) |=> !to_flag);
endmodule

// File: rtl/scl_timing_top.sv
module scl_timing_top
  import scl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [TO_W-1:0]  to_limit,
  input  logic             ctrl_wr,
  input  logic             txd_wr,
  output logic             scl_drive,
  output logic             bus_release,
  output logic             to_flag,
  output logic             to_irq
);
  logic run;
  logic low_phase;

  assign run = en && !to_flag;

  scl_phase_gen #(.W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .low_phase(low_phase)
  );

  scl_hang_watch #(.TW(TO_W), .PW(UNIT_LG)) u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .to_limit(to_limit),
    .clr(ctrl_wr || txd_wr), .to_flag(to_flag), .to_irq(to_irq)
  );

  assign scl_drive   = low_phase && run;
  assign bus_release = to_flag;

  a_r9_release_floats: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |-> (bus_release && !scl_drive));
  a_r4_no_drive_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !scl_drive);
endmodule

// File: tb/scl_timing_top_tb.sv
module scl_timing_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ext_low = 1'b0;
  logic [7:0] hi_cnt = 8'd4;
  logic [7:0] lo_cnt = 8'd4;
  logic [15:0] to_limit = 16'd0;
  logic ctrl_wr = 1'b0;
  logic txd_wr = 1'b0;
  logic scl_in;
  logic scl_drive, bus_release, to_flag, to_irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n_to = 0;

  always #10 clk = ~clk;

  assign scl_in = ~(scl_drive | ext_low);

  scl_timing_top u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .to_limit(to_limit),
    .ctrl_wr(ctrl_wr), .txd_wr(txd_wr), .scl_drive(scl_drive),
    .bus_release(bus_release), .to_flag(to_flag), .to_irq(to_irq)
  );

  // reference model: 0 idle, 1 low, 2 high
  int m_ph = 0;
  int m_el = 0;
  int m_len = 0;
  int m_low = 0;
  bit m_flag = 0;
  bit m_irq = 0;

  function automatic int phase_len(input logic [7:0] c);
    return int'(c) + 1;
  endfunction

  function automatic bit limit_hit(input int low_run, input logic [15:0] n);
    return (n != 0) && (low_run + 1 == int'(n) * 32);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_len = 0; m_low = 0; m_flag = 0; m_irq = 0;
    end else begin
      if (!(en && !m_flag)) m_ph = 0;
      else if (m_ph == 0) begin m_ph = 1; m_el = 0; m_len = phase_len(lo_cnt); end
      else if (m_el == m_len - 1) begin
        m_ph = (m_ph == 1) ? 2 : 1;
        m_el = 0;
        m_len = (m_ph == 2) ? phase_len(hi_cnt) : phase_len(lo_cnt);
      end else m_el++;
      m_irq = 0;
      if (ctrl_wr || txd_wr) begin m_flag = 0; m_low = 0; end
      else if (m_flag || scl_in || to_limit == 0) m_low = 0;
      else if (limit_hit(m_low, to_limit)) begin
        m_flag = 1; m_irq = 1; m_low = 0; n_to++;
      end else m_low++;
    end
  end

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 drive", scl_drive, (m_ph == 1) && en && !m_flag);
    chk("R5 R6 R8 R10 flag", to_flag, m_flag);
    chk("R7 irq", to_irq, m_irq);
    chk("R9 release", bus_release, m_flag);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      ctrl_wr = 1'b0;
      txd_wr = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 drive", scl_drive, 1'b0);
    chk("R1 release", bus_release, 1'b0);
    chk("R1 flag", to_flag, 1'b0);
    chk("R1 irq", to_irq, 1'b0);
    rst_n = 1'b1;
    step(2);
    // R2: directed default phases
    en = 1'b1;
    step(40);
    // R3: change counts mid-phase
    lo_cnt = 8'd9; step(3); hi_cnt = 8'd0; step(30);
    // R4: disable and restart
    en = 1'b0; step(5); en = 1'b1; step(20);
    // R5: long external hold with timeout disabled
    to_limit = 16'd0; ext_low = 1'b1; step(400); ext_low = 1'b0; step(5);
    // R6 R10: external hold with generator off, N=2
    en = 1'b0; to_limit = 16'd2; ext_low = 1'b1; step(70);
    // R8: clear via txd_wr, then recount and clear via ctrl_wr
    txd_wr = 1'b1; step(70); ctrl_wr = 1'b1; step(1);
    ext_low = 1'b0; step(5);
    // R6: own long low phase times out, R9 releases
    en = 1'b1; to_limit = 16'd1; lo_cnt = 8'd40; step(60);
    ctrl_wr = 1'b1; step(3);
    // random segments
    for (int s = 0; s < 60; s++) begin
      en = ($urandom % 4) != 0;
      hi_cnt = 8'($urandom % 12);
      lo_cnt = 8'($urandom % 24);
      case ($urandom % 4)
        0: to_limit = 16'd0;
        1: to_limit = 16'd1;
        2: to_limit = 16'd2;
        default: to_limit = 16'd3;
      endcase
      for (int c = 0; c < 150; c++) begin
        if ($urandom % 60 == 0) ext_low = ~ext_low;
        if ($urandom % 40 == 0) hi_cnt = 8'($urandom % 12);
        if ($urandom % 40 == 0) lo_cnt = 8'($urandom % 24);
        if ($urandom % 90 == 0) ctrl_wr = 1'b1;
        if ($urandom % 90 == 0) txd_wr = 1'b1;
        step(1);
      end
    end
    ext_low = 1'b0;
    step(5);
    total++;
    if (n_to == 0) begin
      bad++;
      $display("FAIL R6 timeouts seen: actual=%0d expected>0", n_to);
    end
    report();
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end
endmodule